// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit keeps the 16-bit stack pointer of an 8-bit processor. Software reaches the pointer as two 8-bit I/O registers, one for the upper byte and one for the lower byte. Instruction decode issues stack requests to the unit. A data push or pop moves one byte. A call, an interrupt entry or a return moves a two-byte return address. For every request the unit drives the data-memory address of each byte that moves, together with write or read enables.

The stack grows downward. A push stores at the address the pointer holds and then lowers the pointer. A pop first raises the pointer and then reads. Software must place the pointer above 0x60 before any call or interrupt. The unit raises a sticky underflow flag if a push writes any byte at or below 0x60.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the upper byte, the lower byte and the underflow flag are all zero.
- R2: A write to the upper or lower byte register loads `wdata_i` into that byte at the next clock edge and leaves the other byte unchanged. Both bytes may be written in the same cycle.
- R3: A byte write blocks any stack request in the same cycle. No memory enable is asserted, the pointer takes only the written value, and the flag does not change.
- R4: A data push (`op_i`=1) asserts `mem_we_o` with `mem_addr0_o` equal to the pointer, and the pointer drops by one at the next edge.
- R5: A data pop (`op_i`=2) asserts `mem_re_o` with `mem_addr0_o` equal to the pointer plus one, and the pointer rises by one at the next edge.
- R6: A call or interrupt entry (`op_i`=3) asserts `mem_we_o` and `mem_pair_o`. The low return byte goes to `mem_addr0_o` (the pointer) and the high byte goes to `mem_addr1_o` (the pointer minus one). The pointer drops by two at the next edge.
- R7: A return (`op_i`=4) asserts `mem_re_o` and `mem_pair_o`. The high byte is read at `mem_addr1_o` (the pointer plus one) and the low byte at `mem_addr0_o` (the pointer plus two). The pointer rises by two at the next edge.
- R8: A push or call that writes any byte at an address at or below 0x60 sets `underflow_o` from the next edge on. The flag stays set until reset.
- R9: Pushes and calls whose written addresses are all above 0x60 leave the flag clear. Examples are a push at 0x61 and a call at 0x62.
- R10: Pops and returns never set the flag. Pointer arithmetic wraps modulo 2^16.
- R11: `op_i` of 0, or any code from 5 to 7, is idle. No enable is asserted and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_hi_i | input | 1 | Write strobe for the upper pointer byte |
| wr_lo_i | input | 1 | Write strobe for the lower pointer byte |
| wdata_i | input | 8 | Byte write data |
| op_i | input | 3 | Stack request: 0 idle, 1 push, 2 pop, 3 call, 4 return |
| sp_hi_o | output | 8 | Upper pointer byte |
| sp_lo_o | output | 8 | Lower pointer byte |
| mem_addr0_o | output | 16 | Address of the single byte, or of the low return byte |
| mem_addr1_o | output | 16 | Address of the high return byte |
| mem_we_o | output | 1 | Stack write this cycle |
| mem_re_o | output | 1 | Stack read this cycle |
| mem_pair_o | output | 1 | Two bytes move this cycle |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The hardest case is a call where only the second byte of the pair crosses the floor. The pointer sits at 0x61, so the low byte lands legally and the high byte lands on 0x60. The stimulus writes the pointer through the byte registers to 0x61, 0x62 and similar values near the floor. It then issues pushes and calls from those values. It also wraps the pointer from 0xFFFF to zero with a pop, which shows that reads never raise the flag. A later push far above the floor confirms that the flag stays set.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 16;
  localparam int NBYTES = PTR_W / DATA_W;
  localparam logic [PTR_W-1:0] FLOOR_ADDR = PTR_W'(16'h0060);

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } sp_op_e;
endpackage

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
  import sp_pkg::*;
(
  input  logic [PTR_W-1:0] sp_i,
  input  logic [2:0]       op_i,
  output logic [PTR_W-1:0] addr0_o,
  output logic [PTR_W-1:0] addr1_o,
  output logic             we_o,
  output logic             re_o,
  output logic             pair_o,
  output logic             step_o,
  output logic [PTR_W-1:0] sp_next_o
);
  always_comb begin
    addr0_o   = sp_i;
    addr1_o   = sp_i - PTR_W'(1);
    we_o      = 1'b0;
    re_o      = 1'b0;
    pair_o    = 1'b0;
    sp_next_o = sp_i;
    case (op_i)
      OP_PUSH: begin
        we_o      = 1'b1;
        sp_next_o = sp_i - PTR_W'(1);
      end
      OP_POP: begin
        re_o      = 1'b1;
        addr0_o   = sp_i + PTR_W'(1);
        sp_next_o = sp_i + PTR_W'(1);
      end
      OP_CALL: begin
        we_o      = 1'b1;
        pair_o    = 1'b1;
        sp_next_o = sp_i - PTR_W'(2);
      end
      OP_RET: begin
        re_o      = 1'b1;
        pair_o    = 1'b1;
        addr0_o   = sp_i + PTR_W'(2);
        addr1_o   = sp_i + PTR_W'(1);
        sp_next_o = sp_i + PTR_W'(2);
      end
      default: ;
    endcase
    step_o = we_o | re_o;
  end
endmodule

// File: rtl/sp_reg.sv
module sp_reg
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic [PTR_W-1:0]  sp_next_i,
  output logic [PTR_W-1:0]  sp_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sp_o[b*DATA_W +: DATA_W] <= '0;
      else if (wr_i[b])
        sp_o[b*DATA_W +: DATA_W] <= wdata_i;
      else if (step_i && wr_i == '0)
        sp_o[b*DATA_W +: DATA_W] <= sp_next_i[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sp_floor_chk.sv
module sp_floor_chk
  import sp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             pair_i,
  input  logic [PTR_W-1:0] addr0_i,
  input  logic [PTR_W-1:0] addr1_i,
  output logic             flag_o
);
  logic hit;
  assign hit = we_i && ((addr0_i <= FLOOR_ADDR) || (pair_i && addr1_i <= FLOOR_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (hit) flag_o <= 1'b1;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_hi_i,
  input  logic        wr_lo_i,
  input  logic [7:0]  wdata_i,
  input  logic [2:0]  op_i,
  output logic [7:0]  sp_hi_o,
  output logic [7:0]  sp_lo_o,
  output logic [15:0] mem_addr0_o,
  output logic [15:0] mem_addr1_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic        mem_pair_o,
  output logic        underflow_o
);
  logic [PTR_W-1:0]  sp_q, sp_next;
  logic [NBYTES-1:0] wr_vec;
  logic [2:0]        op_eff;
  logic              step;

  assign wr_vec = {wr_hi_i, wr_lo_i};
  // byte writes win over stack requests
  assign op_eff = (wr_vec != '0) ? 3'(OP_IDLE) : op_i;

  sp_addr_gen i_gen (
    .sp_i      (sp_q),
    .op_i      (op_eff),
    .addr0_o   (mem_addr0_o),
    .addr1_o   (mem_addr1_o),
    .we_o      (mem_we_o),
    .re_o      (mem_re_o),
    .pair_o    (mem_pair_o),
    .step_o    (step),
    .sp_next_o (sp_next)
  );

  sp_reg i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_vec),
    .wdata_i   (wdata_i),
    .step_i    (step),
    .sp_next_i (sp_next),
    .sp_o      (sp_q)
  );

  sp_floor_chk i_floor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we_o),
    .pair_i  (mem_pair_o),
    .addr0_i (mem_addr0_o),
    .addr1_i (mem_addr1_o),
    .flag_o  (underflow_o)
  );

  assign sp_hi_o = sp_q[15:8];
  assign sp_lo_o = sp_q[7:0];
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_hi_i,
  input logic        wr_lo_i,
  input logic [7:0]  wdata_i,
  input logic [2:0]  op_i,
  input logic [7:0]  sp_hi_o,
  input logic [7:0]  sp_lo_o,
  input logic [15:0] mem_addr0_o,
  input logic [15:0] mem_addr1_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic        mem_pair_o,
  input logic        underflow_o
);
  logic [15:0] sp;
  logic        wr_any;
  assign sp     = {sp_hi_o, sp_lo_o};
  assign wr_any = wr_hi_i | wr_lo_i;

  assert_hi_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> sp_hi_o == $past(wdata_i));
  assert_lo_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> sp_lo_o == $past(wdata_i));
  assert_write_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |-> !mem_we_o && !mem_re_o);
  assert_push_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && op_i == 3'd1) |=> sp == $past(sp) - 16'd1);
  assert_pop_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && op_i == 3'd2) |=> sp == $past(sp) + 16'd1);
  assert_call_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && op_i == 3'd3) |=> sp == $past(sp) - 16'd2);
  assert_ret_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && op_i == 3'd4) |=> sp == $past(sp) + 16'd2);
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  assert_read_no_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!underflow_o && mem_re_o) |=> !underflow_o);
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && (op_i == 3'd0 || op_i > 3'd4)) |=> $stable(sp));
  assert_enable_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind stack_ptr_unit sp_checker i_sp_checker (.*);

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_hi_i = 1'b0, wr_lo_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  op_i = '0;
  logic [7:0]  sp_hi_o, sp_lo_o;
  logic [15:0] mem_addr0_o, mem_addr1_o;
  logic        mem_we_o, mem_re_o, mem_pair_o, underflow_o;

  stack_ptr_unit i_stack_ptr_unit (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [15:0] sp;
    logic        uf, we, re, pair;
    logic [15:0] a0, a1;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic [15:0] m_sp = '0;
  logic        m_uf = 1'b0;
  bit          done = 1'b0;

  task automatic step(input logic wh, input logic wl, input logic [7:0] wd,
                      input logic [2:0] op, input string tag);
    exp_t e;
    logic wr;
    @(negedge clk_i);
    wr_hi_i = wh; wr_lo_i = wl; wdata_i = wd; op_i = op;
    wr = wh | wl;
    e.sp = m_sp; e.uf = m_uf; e.tag = tag;
    e.we = !wr && (op == 3'd1 || op == 3'd3);
    e.re = !wr && (op == 3'd2 || op == 3'd4);
    e.pair = !wr && (op == 3'd3 || op == 3'd4);
    e.a0 = m_sp; e.a1 = m_sp - 16'd1;
    if (!wr && op == 3'd2) e.a0 = m_sp + 16'd1;
    if (!wr && op == 3'd4) begin e.a0 = m_sp + 16'd2; e.a1 = m_sp + 16'd1; end
    q.push_back(e);
    if (wr) begin
      if (wh) m_sp[15:8] = wd;
      if (wl) m_sp[7:0] = wd;
    end else begin
      if (e.we && (e.a0 <= 16'h0060 || (e.pair && e.a1 <= 16'h0060))) m_uf = 1'b1;
      case (op)
        3'd1: m_sp = m_sp - 16'd1;
        3'd2: m_sp = m_sp + 16'd1;
        3'd3: m_sp = m_sp - 16'd2;
        3'd4: m_sp = m_sp + 16'd2;
        default: ;
      endcase
    end
  endtask

  task automatic set_sp(input logic [15:0] v, input string tag);
    step(1'b1, 1'b1, v[15:8], 3'd0, tag); // both bytes same value only if equal
    if (v[15:8] != v[7:0]) step(1'b0, 1'b1, v[7:0], 3'd0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        ok = ({sp_hi_o, sp_lo_o} === e.sp) && (underflow_o === e.uf) &&
             (mem_we_o === e.we) && (mem_re_o === e.re) && (mem_pair_o === e.pair);
        if (e.we || e.re) ok = ok && (mem_addr0_o === e.a0);
        if (e.pair) ok = ok && (mem_addr1_o === e.a1);
        n_chk++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: got sp=%h uf=%b we=%b re=%b pr=%b a0=%h a1=%h exp sp=%h uf=%b we=%b re=%b pr=%b a0=%h a1=%h",
                   e.tag, {sp_hi_o, sp_lo_o}, underflow_o, mem_we_o, mem_re_o, mem_pair_o,
                   mem_addr0_o, mem_addr1_o, e.sp, e.uf, e.we, e.re, e.pair, e.a0, e.a1);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 8'h00, 3'd0, "R1 reset state");
    step(1, 0, 8'h01, 3'd0, "R2 write hi");
    step(0, 1, 8'h80, 3'd0, "R2 write lo");
    step(0, 0, 8'h00, 3'd1, "R4 push");
    step(0, 0, 8'h00, 3'd1, "R4 push second");
    step(0, 0, 8'h00, 3'd2, "R5 pop");
    step(0, 0, 8'h00, 3'd3, "R6 call");
    step(0, 0, 8'h00, 3'd4, "R7 return");
    step(0, 0, 8'h00, 3'd6, "R11 idle code 6");
    step(0, 0, 8'h00, 3'd0, "R11 idle code 0");
    step(0, 1, 8'h40, 3'd3, "R3 write beats call");
    step(1, 0, 8'h02, 3'd1, "R3 write beats push");
    step(1, 1, 8'hFF, 3'd0, "R2 both bytes");
    step(0, 0, 8'h00, 3'd2, "R10 pop wraps");
    step(0, 0, 8'h00, 3'd4, "R10 return low");
    step(1, 0, 8'h00, 3'd0, "R9 set hi");
    step(0, 1, 8'h61, 3'd0, "R9 set lo");
    step(0, 0, 8'h00, 3'd1, "R9 push at 0x61");
    step(0, 1, 8'h62, 3'd0, "R9 set 0x62");
    step(0, 0, 8'h00, 3'd3, "R9 call at 0x62");
    step(0, 1, 8'h61, 3'd0, "R8 set 0x61");
    step(0, 0, 8'h00, 3'd3, "R8 call high byte at 0x60");
    step(1, 1, 8'h22, 3'd0, "R8 flag set");
    step(0, 0, 8'h00, 3'd1, "R8 push high");
    step(0, 0, 8'h00, 3'd7, "R8 sticky");
    step(0, 0, 8'h00, 3'd0, "R8 sticky end");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule